// File: doc/BRIEF.md
# Programmable Trigger Delay Generator

This block turns one edge on a chosen hardware trigger line into a set of precisely timed digital pulses. A rising edge on the selected input starts a 16-bit counter from zero. The counter advances once per prescaler period. When the count equals either of two programmed delay values, the matching output gives a one-clock pulse. A window output stays high over the span between the two delay points, so it can gate an analog comparator. When the count reaches the programmed terminal value the sequence ends and a sticky interrupt flag is raised.

Three operating modes are provided. In one-shot mode the unit runs once and then stays disarmed until the control register is written again. In repeating mode the unit re-arms itself after every sequence. In pass-through mode every selected edge reaches both pulse outputs at once, with no counting. Delay and terminal values are written into holding registers and move into the working set only on an explicit load command given while the counter is idle. A running sequence therefore never sees a half-updated configuration.

Top module: `trig_delay_gen`

## Requirements
- R1: The control register (address 0) bits [2:0] choose which of the seven trigger inputs is watched (0 to 6). Rising edges on any input that is not selected have no effect on any output.
- R2: A rising edge on the selected input starts the counter from zero. With divide D and delay d, the matching pulse is high in the single clock that follows edge d*D+2, where edge 1 is the first clock edge at which the raised input is sampled.
- R3: Control bits [5:3] hold a prescaler code p. The counter advances once every 2^p clocks, so p = 0 gives 1 and p = 7 gives 128.
- R4: Two independent delay values are held: address 1 drives `dly0_pulse` and address 2 drives `dly1_pulse`. Each output pulses for exactly one clock per sequence.
- R5: When control bit 8 is set, `trig_or` carries the OR of both delay pulses. When the bit is clear, `trig_or` stays low.
- R6: `window` goes high together with the first delay pulse and falls together with the second. It is therefore high for (delay1 - delay0) * D clocks.
- R7: When the count equals the terminal value (address 3), counting stops and `irq` is set at edge terminal*D+2. The flag stays set until a control write with bit 10 at 1 clears it.
- R8: In one-shot mode (control bits [7:6] = 00), a finished sequence disarms the unit. Later triggers are ignored until the control register is written again.
- R9: In repeating mode (bits [7:6] = 01), the unit re-arms on its own. Every new rising edge after completion starts a fresh sequence.
- R10: A rising edge that arrives while the counter is running is ignored. It neither restarts nor shifts the sequence in progress.
- R11: In pass-through mode (bits [7:6] = 10), a selected rising edge produces a one-clock pulse on both delay outputs at the first edge where it is sampled. No window is produced.
- R12: Writes to addresses 1 to 3 go only to holding registers. They are copied to the working set by a control write with bit 9 at 1, and only if the counter is idle. A load request made while the counter runs is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 7 | Hardware trigger candidates |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 delay0, 2 delay1, 3 terminal |
| wr_data | input | 16 | Register write data |
| dly0_pulse | output | 1 | First delayed trigger pulse |
| dly1_pulse | output | 1 | Second delayed trigger pulse |
| trig_or | output | 1 | OR of both delayed pulses, when enabled |
| window | output | 1 | Comparator window between the delay points |
| irq | output | 1 | Sticky sequence-complete flag |

## Verification
The delay path is driven with a unit divide and with a divide of four. Comparing the two runs separates prescaler errors from off-by-one errors in the compare and start logic. Edges are applied on an unselected input, repeated in one-shot and in repeating mode, and re-applied in the middle of a run; these show that arming and edge rejection are correct and not just the timing. A load request made while the counter runs is followed by a sequence that must still use the old delay, and then an idle load must move that delay. Pass-through mode and a disabled OR output confirm that each mode changes only the outputs it should.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
    localparam int CNT_W     = 16;
    localparam int N_SRC     = 7;
    localparam int SEL_W     = 3;
    localparam int PRE_W     = 3;
    localparam int PRE_CNT_W = (1 << PRE_W) - 1;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = 16;
    localparam int N_CH      = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_DLY0 = 2'd1;
    localparam logic [ADDR_W-1:0] A_DLY1 = 2'd2;
    localparam logic [ADDR_W-1:0] A_TERM = 2'd3;
    localparam int B_LOAD = 9;
    localparam int B_CLR  = 10;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_REPEAT  = 2'b01,
        MODE_PASS    = 2'b10,
        MODE_SPARE   = 2'b11
    } mode_e;

    typedef struct packed {
        logic               or_en;
        mode_e              mode;
        logic [PRE_W-1:0]   pre_code;
        logic [SEL_W-1:0]   src_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [CNT_W-1:0] dly1;
        logic [CNT_W-1:0] dly0;
        logic [CNT_W-1:0] term;
    } timing_t;

    function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PRE_W-1:0] code);
        logic [PRE_CNT_W:0] span;
        span = (PRE_CNT_W + 1)'(1) << code;
        return PRE_CNT_W'(span - 1'b1);
    endfunction
endpackage

// File: rtl/tdg_regs.sv
module tdg_regs
    import tdg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                busy,
    output ctrl_t               ctrl,
    output timing_t             act,
    output logic                ctrl_wr,
    output logic                irq_clr
);
    timing_t hold;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign irq_clr = ctrl_wr && wr_data[B_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            hold <= '0;
            act  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    if (wr_data[B_LOAD] && !busy)
                        act <= hold;
                end
                A_DLY0:  hold.dly0 <= wr_data[CNT_W-1:0];
                A_DLY1:  hold.dly1 <= wr_data[CNT_W-1:0];
                default: hold.term <= wr_data[CNT_W-1:0];
            endcase
        end
    end

    // R12: the working set never moves during a running sequence
    a_r12_active_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(act));
endmodule

// File: rtl/tdg_trig.sv
module tdg_trig
    import tdg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SRC-1:0]    trig_in,
    input  logic [SEL_W-1:0]    src_sel,
    output logic                rise
);
    localparam int SPAN = 1 << SEL_W;

    logic [SPAN-1:0] padded;
    logic            cur;
    logic            prev;

    assign padded = SPAN'(trig_in);
    assign cur    = padded[src_sel];
    assign rise   = cur && !prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= cur;
    end

    // R1: an edge is a single-cycle event
    a_r1_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/tdg_count.sv
module tdg_count
    import tdg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  ctrl_t               ctrl,
    input  timing_t             act,
    input  logic                ctrl_wr,
    input  logic                irq_clr,
    output logic                running,
    output logic [CNT_W-1:0]    cnt,
    output logic                irq
);
    logic [PRE_CNT_W-1:0] pre_cnt;
    logic                 armed;
    logic                 start;
    logic                 done;
    logic                 tick;

    assign start = rise && !running && armed && (ctrl.mode != MODE_PASS);
    assign done  = running && (cnt == act.term);
    assign tick  = pre_cnt >= pre_limit(ctrl.pre_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            pre_cnt <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
            pre_cnt <= '0;
        end else if (done) begin
            running <= 1'b0;
        end else if (running) begin
            if (tick) begin
                pre_cnt <= '0;
                cnt     <= cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (ctrl_wr) begin
            armed <= 1'b1;
        end else if (done && (ctrl.mode != MODE_REPEAT)) begin
            armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (done)    irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    // R7: flag holds until cleared
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);
    // R7: count never passes the terminal value
    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt <= act.term));
    // R2: count advances by at most one per clock
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (running && !done) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
    // R10: an unfinished sequence keeps running whatever the trigger does
    a_r10_run_holds: assert property (@(posedge clk) disable iff (rst)
        (running && !done) |=> running);
endmodule

// File: rtl/tdg_out.sv
module tdg_out
    import tdg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rise,
    input  logic                        pass,
    input  logic                        or_en,
    input  logic                        running,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [N_CH-1:0][CNT_W-1:0]  dly,
    output logic [N_CH-1:0]             pulse,
    output logic                        window,
    output logic                        trig_or
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic fired;
        logic hit;

        assign hit = running && (cnt == dly[ch]) && !fired;

        always_ff @(posedge clk) begin
            if (rst) begin
                fired     <= 1'b0;
                pulse[ch] <= 1'b0;
            end else begin
                fired     <= running && (fired || hit);
                pulse[ch] <= pass ? rise : hit;
            end
        end

        // R4: every delayed pulse lasts one clock
        a_r4_pulse_one_clk: assert property (@(posedge clk) disable iff (rst)
            pulse[ch] |=> !pulse[ch]);
    end

    always_ff @(posedge clk) begin
        if (rst) window <= 1'b0;
        else     window <= !pass && running && (cnt >= dly[0]) && (cnt < dly[1]);
    end

    assign trig_or = or_en && (|pulse);

    // R6: window only follows a running count
    a_r6_window_needs_run: assert property (@(posedge clk) disable iff (rst)
        (!running && !window) |=> !window);
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen
    import tdg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SRC-1:0]    trig_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                dly0_pulse,
    output logic                dly1_pulse,
    output logic                trig_or,
    output logic                window,
    output logic                irq
);
    ctrl_t                      ctrl;
    timing_t                    act;
    logic                       ctrl_wr;
    logic                       irq_clr;
    logic                       rise;
    logic                       running;
    logic [CNT_W-1:0]           cnt;
    logic [N_CH-1:0]            pulse;
    logic [N_CH-1:0][CNT_W-1:0] dly;

    assign dly        = {act.dly1, act.dly0};
    assign dly0_pulse = pulse[0];
    assign dly1_pulse = pulse[1];

    tdg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(running), .ctrl(ctrl), .act(act), .ctrl_wr(ctrl_wr), .irq_clr(irq_clr)
    );

    tdg_trig u_trig (
        .clk(clk), .rst(rst), .trig_in(trig_in), .src_sel(ctrl.src_sel), .rise(rise)
    );

    tdg_count u_count (
        .clk(clk), .rst(rst), .rise(rise), .ctrl(ctrl), .act(act),
        .ctrl_wr(ctrl_wr), .irq_clr(irq_clr), .running(running), .cnt(cnt), .irq(irq)
    );

    tdg_out u_out (
        .clk(clk), .rst(rst), .rise(rise), .pass(ctrl.mode == MODE_PASS),
        .or_en(ctrl.or_en), .running(running), .cnt(cnt), .dly(dly),
        .pulse(pulse), .window(window), .trig_or(trig_or)
    );
endmodule

// File: tb/trig_delay_gen_bench.sv
module trig_delay_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  trig_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        dly0_pulse, dly1_pulse, trig_or, window, irq;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    int n_p0, f_p0, n_p1, f_p1, n_win, f_win, n_or, f_irq;

    always #2.5 clk = ~clk;

    trig_delay_gen u_trig_delay_gen (
        .clk(clk), .rst(rst), .trig_in(trig_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dly0_pulse(dly0_pulse), .dly1_pulse(dly1_pulse),
        .trig_or(trig_or), .window(window), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] mk(input int sel, input int pre, input int mode,
                                       input bit or_en, input bit load, input bit clr);
        return {5'b0, clr, load, or_en, 2'(mode), 3'(pre), 3'(sel)};
    endfunction

    task automatic set_timing(input int d0, input int d1, input int term);
        wr(2'd1, 16'(d0));
        wr(2'd2, 16'(d1));
        wr(2'd3, 16'(term));
    endtask

    task automatic capture(input int src, input int len, input int retrig_at);
        n_p0 = 0; f_p0 = 0; n_p1 = 0; f_p1 = 0; n_win = 0; f_win = 0; n_or = 0; f_irq = 0;
        trig_in[src] = 1'b1;
        for (int n = 1; n <= len; n++) begin
            if (n == retrig_at)     trig_in[src] = 1'b0;
            if (n == retrig_at + 1) trig_in[src] = 1'b1;
            step();
            if (dly0_pulse) begin n_p0++; if (f_p0 == 0) f_p0 = n; end
            if (dly1_pulse) begin n_p1++; if (f_p1 == 0) f_p1 = n; end
            if (window)     begin n_win++; if (f_win == 0) f_win = n; end
            if (trig_or)    n_or++;
            if (irq && f_irq == 0) f_irq = n;
        end
        trig_in[src] = 1'b0;
        step();
        step();
    endtask

    task automatic t_reset();
        check("R7", "reset irq", int'(irq), 0);
        check("R4", "reset pulses", int'({dly0_pulse, dly1_pulse, trig_or, window}), 0);
    endtask

    task automatic t_basic();
        set_timing(3, 6, 9);
        wr(2'd0, mk(2, 0, 0, 1, 1, 0));
        capture(2, 16, 0);
        check("R2", "dly0 pulse edge", f_p0, 5);
        check("R4", "dly0 pulse count", n_p0, 1);
        check("R4", "dly1 pulse edge", f_p1, 8);
        check("R6", "window length", n_win, 3);
        check("R6", "window start", f_win, 5);
        check("R5", "or output count", n_or, 2);
        check("R7", "irq edge", f_irq, 11);
        repeat (3) step();
        check("R7", "irq sticky", int'(irq), 1);
    endtask

    task automatic t_irq_clear();
        wr(2'd0, mk(2, 0, 0, 1, 0, 1));
        check("R7", "irq cleared", int'(irq), 0);
    endtask

    task automatic t_select();
        capture(5, 16, 0);
        check("R1", "unselected input pulses", n_p0 + n_p1 + n_win, 0);
        check("R1", "unselected input irq", f_irq, 0);
    endtask

    task automatic t_oneshot();
        capture(2, 16, 0);
        check("R8", "armed run dly0 edge", f_p0, 5);
        capture(2, 16, 0);
        check("R8", "disarmed run pulses", n_p0 + n_p1, 0);
        wr(2'd0, mk(2, 0, 0, 1, 0, 1));
        capture(2, 16, 0);
        check("R8", "rearmed run dly0 edge", f_p0, 5);
    endtask

    task automatic t_prescale();
        set_timing(1, 2, 3);
        wr(2'd0, mk(2, 2, 0, 1, 1, 1));
        capture(2, 20, 0);
        check("R3", "div4 dly0 edge", f_p0, 6);
        check("R3", "div4 dly1 edge", f_p1, 10);
        check("R6", "div4 window length", n_win, 4);
        check("R7", "div4 irq edge", f_irq, 14);
    endtask

    task automatic t_or_off();
        wr(2'd0, mk(2, 0, 0, 0, 0, 1));
        capture(2, 10, 0);
        check("R5", "or disabled count", n_or, 0);
        check("R5", "dly0 still pulses", n_p0, 1);
    endtask

    task automatic t_repeat();
        set_timing(3, 6, 9);
        wr(2'd0, mk(2, 0, 1, 1, 1, 1));
        capture(2, 16, 0);
        check("R9", "first run dly0 edge", f_p0, 5);
        capture(2, 16, 0);
        check("R9", "second run dly0 edge", f_p0, 5);
        check("R9", "second run dly1 edge", f_p1, 8);
    endtask

    task automatic t_retrig();
        set_timing(8, 12, 20);
        wr(2'd0, mk(2, 0, 1, 1, 1, 1));
        capture(2, 30, 3);
        check("R10", "dly0 count with retrigger", n_p0, 1);
        check("R10", "dly0 edge with retrigger", f_p0, 10);
        check("R10", "irq edge with retrigger", f_irq, 22);
    endtask

    task automatic t_load();
        set_timing(3, 6, 30);
        wr(2'd0, mk(2, 0, 1, 1, 1, 1));
        trig_in[2] = 1'b1;
        repeat (5) step();
        wr(2'd1, 16'd10);
        wr(2'd0, mk(2, 0, 1, 1, 1, 1));
        repeat (40) step();
        trig_in[2] = 1'b0;
        step(); step();
        capture(2, 40, 0);
        check("R12", "busy load dropped", f_p0, 5);
        wr(2'd0, mk(2, 0, 1, 1, 1, 1));
        capture(2, 40, 0);
        check("R12", "idle load applied", f_p0, 12);
    endtask

    task automatic t_pass();
        wr(2'd0, mk(2, 0, 2, 1, 0, 1));
        capture(2, 10, 0);
        check("R11", "pass dly0 edge", f_p0, 1);
        check("R11", "pass dly0 count", n_p0, 1);
        check("R11", "pass dly1 edge", f_p1, 1);
        check("R11", "pass window", n_win, 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_basic();
        t_irq_clear();
        t_select();
        t_oneshot();
        t_prescale();
        t_or_off();
        t_repeat();
        t_retrig();
        t_load();
        t_pass();
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule